// File: doc/BRIEF.md
# Split Host Port Command Decoder

This block sits on the host side of a network controller and turns pairs of 16-bit bus writes into 32-bit port commands. The host writes the lower half of a port word first and the upper half second. When the upper half lands, the lowest nibble of the word picks one of five commands and the rest of the word, with that nibble cleared, gives the address the command works on.

Each legal command leaves the block as a one-cycle pulse on its own output, with the address held beside it. The block also keeps three pieces of controller state that the commands act on. These are the configuration-block pointer, the link status word and a pending interrupt request. Other units raise the interrupt request and write the link status. A software reset command puts all three back to their power-on values. Nibble values with no command behind them produce no pulse and leave a sticky error flag set.

Top module: `port_cmd_unit`

## Requirements
- R1: A write taken while the half-word toggle is clear stores bits 15:0 and issues nothing. The next write supplies bits 31:16 and issues the command. The toggle flips on every accepted write and holds when no write is taken.
- R2: Command codes in bits 3:0 are 0 software reset, 1 self-test, 2 alternate pointer load, 3 dump and 4 channel attention. Each legal code raises only its own pulse output, for exactly one cycle, in the cycle after the upper-half write.
- R3: `cmd_addr` equals the assembled 32-bit word with bits 3:0 forced to zero. It becomes valid together with the pulse and holds until the next legal command.
- R4: `selftest_addr` is always `cmd_addr` plus 4, which is where the self-test result is stored.
- R5: A software reset command sets `cfg_ptr` to 0x00FFFFF4, sets `link_status` to 0x8000 (link up) and clears `irq_pending`. These values are visible in the same cycle as the reset pulse. The command wins over `irq_raise` or `link_we` in the same cycle.
- R6: An alternate pointer command loads `cfg_ptr` from the delivered address, visible in the same cycle as its pulse.
- R7: Codes 5 to 15 raise no pulse, leave `cmd_addr` unchanged and set `illegal_cmd`. Only the hardware reset clears `illegal_cmd`.
- R8: While `rst_n` is low, the block clears the half-word toggle, clears all pulses, `cmd_addr`, `irq_pending` and `illegal_cmd`, and loads 0x00FFFFF4 into `cfg_ptr` and 0x8000 into `link_status`. The first write after reset is taken as a lower half.
- R9: A high `irq_raise` sets `irq_pending`, which stays set until a software reset. A high `link_we` loads `link_val` into `link_status`.
- R10: Self-test, dump, channel attention and illegal codes leave `cfg_ptr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Half-word write strobe |
| wr_data | input | 16 | Half-word write data |
| irq_raise | input | 1 | Sets the pending interrupt request |
| link_we | input | 1 | Loads the link status word |
| link_val | input | 16 | New link status word |
| pulse_reset | output | 1 | Software reset command pulse |
| pulse_selftest | output | 1 | Self-test command pulse |
| pulse_altptr | output | 1 | Alternate pointer command pulse |
| pulse_dump | output | 1 | Dump command pulse |
| pulse_attn | output | 1 | Channel attention command pulse |
| cmd_addr | output | 32 | Address of the last legal command, low nibble zero |
| selftest_addr | output | 32 | Self-test result location, `cmd_addr` + 4 |
| cfg_ptr | output | 32 | Configuration-block pointer |
| link_status | output | 16 | Link status word |
| irq_pending | output | 1 | Pending interrupt request |
| illegal_cmd | output | 1 | Sticky flag for an unknown command code |

## Verification
The riskiest internal state is the half-word toggle. If it gets out of step, every later command is built from the wrong halves. The ports show this on the very next pair: a pulse arrives one write early, or `cmd_addr` comes back with its halves swapped. The bench checks that no pulse follows each lower half and checks the pulse and address one cycle after each upper half. It also sets a hardware reset between the two halves of a pair to confirm the toggle restarts. A stuck pulse, or state loaded on the wrong edge, shows up in `cfg_ptr`, `link_status` or `irq_pending` one cycle after the upper-half write. Those outputs are compared against a running model after every command.

// File: rtl/port_cmd_pkg.sv
package port_cmd_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int CODE_W   = 4;
    localparam int NUM_CMDS = 5;

    // Positions in the pulse vector equal the command code.
    typedef enum logic [CODE_W-1:0] {
        PC_SWRESET  = 4'd0,
        PC_SELFTEST = 4'd1,
        PC_ALTPTR   = 4'd2,
        PC_DUMP     = 4'd3,
        PC_ATTN     = 4'd4
    } port_code_e;

    localparam logic [WORD_W-1:0] CFG_PTR_RST = 32'h00FF_FFF4;
    localparam logic [HALF_W-1:0] LINK_RST    = 16'h8000;
    localparam logic [WORD_W-1:0] RESULT_OFS  = 32'd4;

endpackage

// File: rtl/port_half_assembler.sv
module port_half_assembler #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_data,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic              upper;
        logic [HALF_W-1:0] low;
    } asm_t;

    asm_t asm_d, asm_q;

    always_comb begin
        asm_d = asm_q;
        if (wr_en) begin
            if (!asm_q.upper) begin
                asm_d.low   = wr_data;
                asm_d.upper = 1'b1;
            end else begin
                asm_d.upper = 1'b0;
            end
        end
        word_valid_o = wr_en && asm_q.upper;
        word_o       = {wr_data, asm_q.low};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    // R1: every accepted write flips the toggle
    a_r1_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (asm_q.upper != $past(asm_q.upper)));

    // R1: no write, no change of phase
    a_r1_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(asm_q.upper));

endmodule

// File: rtl/port_cmd_decode.sv
module port_cmd_decode #(
    parameter int WORD_W   = 32,
    parameter int CODE_W   = 4,
    parameter int NUM_CMDS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic [NUM_CMDS-1:0] hit_o,
    output logic [WORD_W-1:0]   addr_d_o,
    output logic [NUM_CMDS-1:0] pulse_o,
    output logic [WORD_W-1:0]   addr_o,
    output logic                illegal_o
);

    typedef struct packed {
        logic [NUM_CMDS-1:0] pulse;
        logic [WORD_W-1:0]   addr;
        logic                illegal;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [CODE_W-1:0] code;
    logic              illegal_now;

    assign code     = word_i[CODE_W-1:0];
    assign addr_d_o = {word_i[WORD_W-1:CODE_W], {CODE_W{1'b0}}};

    for (genvar gi = 0; gi < NUM_CMDS; gi++) begin : g_hit
        assign hit_o[gi] = word_valid_i && (code == CODE_W'(gi));
    end

    assign illegal_now = word_valid_i && (code >= CODE_W'(NUM_CMDS));

    always_comb begin
        dec_d       = dec_q;
        dec_d.pulse = hit_o;
        if (|hit_o) begin
            dec_d.addr = addr_d_o;
        end
        if (illegal_now) begin
            dec_d.illegal = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign pulse_o   = dec_q.pulse;
    assign addr_o    = dec_q.addr;
    assign illegal_o = dec_q.illegal;

    // R2: at most one command pulse at a time
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_q.pulse));

    // R2: a pulse only follows a completed word
    a_r2_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        (|dec_q.pulse) |-> $past(word_valid_i));

    // R7: an unknown code gives no pulse
    a_r7_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && (word_i[CODE_W-1:0] >= CODE_W'(NUM_CMDS))) |=> (dec_q.pulse == '0));

    // R7: the error flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.illegal |=> dec_q.illegal);

    // R3: delivered address never carries code bits
    a_r3_addr_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (|dec_q.pulse) |-> (dec_q.addr[CODE_W-1:0] == '0));

endmodule

// File: rtl/port_state_regs.sv
module port_state_regs #(
    parameter int ADDR_W = 32,
    parameter int LINK_W = 16,
    parameter logic [ADDR_W-1:0] CFG_RST  = 32'h00FF_FFF4,
    parameter logic [LINK_W-1:0] LINK_RST = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset_i,
    input  logic              alt_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              irq_raise_i,
    input  logic              link_we_i,
    input  logic [LINK_W-1:0] link_val_i,
    output logic [ADDR_W-1:0] cfg_ptr_o,
    output logic [LINK_W-1:0] link_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] cfg;
        logic [LINK_W-1:0] link;
        logic              irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (link_we_i) begin
            st_d.link = link_val_i;
        end
        if (irq_raise_i) begin
            st_d.irq = 1'b1;
        end
        if (alt_load_i) begin
            st_d.cfg = addr_i;
        end
        if (sw_reset_i) begin
            st_d.cfg  = CFG_RST;
            st_d.link = LINK_RST;
            st_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= CFG_RST;
            st_q.link <= LINK_RST;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_ptr_o = st_q.cfg;
    assign link_o    = st_q.link;
    assign irq_o     = st_q.irq;

    // R5: software reset restores all three values
    a_r5_sw_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset_i |=> (st_q.cfg == CFG_RST && st_q.link == LINK_RST && !st_q.irq));

    // R6: alternate pointer load takes the address
    a_r6_alt_load: assert property (@(posedge clk) disable iff (!rst_n)
        alt_load_i |=> (st_q.cfg == $past(addr_i)));

    // R10: pointer moves only on reset or alternate load
    a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_load_i && !sw_reset_i) |=> $stable(st_q.cfg));

    // R9: the request stays pending until a software reset
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !sw_reset_i) |=> st_q.irq);

endmodule

// File: rtl/port_cmd_unit.sv
module port_cmd_unit
    import port_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              irq_raise,
    input  logic              link_we,
    input  logic [HALF_W-1:0] link_val,
    output logic              pulse_reset,
    output logic              pulse_selftest,
    output logic              pulse_altptr,
    output logic              pulse_dump,
    output logic              pulse_attn,
    output logic [WORD_W-1:0] cmd_addr,
    output logic [WORD_W-1:0] selftest_addr,
    output logic [WORD_W-1:0] cfg_ptr,
    output logic [HALF_W-1:0] link_status,
    output logic              irq_pending,
    output logic              illegal_cmd
);

    logic                word_valid;
    logic [WORD_W-1:0]   word;
    logic [NUM_CMDS-1:0] hit;
    logic [WORD_W-1:0]   addr_d;
    logic [NUM_CMDS-1:0] pulse;

    port_half_assembler #(.HALF_W(HALF_W)) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .word_valid_o (word_valid),
        .word_o       (word)
    );

    port_cmd_decode #(
        .WORD_W   (WORD_W),
        .CODE_W   (CODE_W),
        .NUM_CMDS (NUM_CMDS)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid_i (word_valid),
        .word_i       (word),
        .hit_o        (hit),
        .addr_d_o     (addr_d),
        .pulse_o      (pulse),
        .addr_o       (cmd_addr),
        .illegal_o    (illegal_cmd)
    );

    port_state_regs #(
        .ADDR_W   (WORD_W),
        .LINK_W   (HALF_W),
        .CFG_RST  (CFG_PTR_RST),
        .LINK_RST (LINK_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset_i  (hit[PC_SWRESET]),
        .alt_load_i  (hit[PC_ALTPTR]),
        .addr_i      (addr_d),
        .irq_raise_i (irq_raise),
        .link_we_i   (link_we),
        .link_val_i  (link_val),
        .cfg_ptr_o   (cfg_ptr),
        .link_o      (link_status),
        .irq_o       (irq_pending)
    );

    assign pulse_reset    = pulse[PC_SWRESET];
    assign pulse_selftest = pulse[PC_SELFTEST];
    assign pulse_altptr   = pulse[PC_ALTPTR];
    assign pulse_dump     = pulse[PC_DUMP];
    assign pulse_attn     = pulse[PC_ATTN];
    assign selftest_addr  = cmd_addr + RESULT_OFS;

    // R2: a command pulse never repeats on the next cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |=> (pulse == '0));

endmodule

// File: tb/port_cmd_unit_test.sv
module port_cmd_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_raise = 1'b0;
    logic        link_we = 1'b0;
    logic [15:0] link_val = '0;
    logic        pulse_reset, pulse_selftest, pulse_altptr, pulse_dump, pulse_attn;
    logic [31:0] cmd_addr, selftest_addr, cfg_ptr;
    logic [15:0] link_status;
    logic        irq_pending, illegal_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_addr, m_cfg;
    logic [15:0] m_link;
    logic        m_irq, m_ill;

    always #10 clk = ~clk;

    port_cmd_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_raise(irq_raise), .link_we(link_we), .link_val(link_val),
        .pulse_reset(pulse_reset), .pulse_selftest(pulse_selftest),
        .pulse_altptr(pulse_altptr), .pulse_dump(pulse_dump), .pulse_attn(pulse_attn),
        .cmd_addr(cmd_addr), .selftest_addr(selftest_addr), .cfg_ptr(cfg_ptr),
        .link_status(link_status), .irq_pending(irq_pending), .illegal_cmd(illegal_cmd)
    );

    function automatic logic [4:0] exp_pulses(input logic [31:0] w);
        logic [4:0] v = '0;
        if (w[3:0] < 4'd5) v[w[3:0]] = 1'b1;
        return v;
    endfunction

    function automatic logic [4:0] got_pulses();
        return {pulse_attn, pulse_dump, pulse_altptr, pulse_selftest, pulse_reset};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic model_hw_reset();
        m_addr = '0; m_cfg = 32'h00FF_FFF4; m_link = 16'h8000; m_irq = 1'b0; m_ill = 1'b0;
    endtask

    task automatic check_state(input string req);
        check({req, " cmd_addr"}, cmd_addr, m_addr);
        check({req, " selftest_addr"}, selftest_addr, m_addr + 32'd4);
        check({req, " cfg_ptr"}, cfg_ptr, m_cfg);
        check({req, " link"}, {16'h0, link_status}, {16'h0, m_link});
        check({req, " irq"}, {31'h0, irq_pending}, {31'h0, m_irq});
        check({req, " illegal"}, {31'h0, illegal_cmd}, {31'h0, m_ill});
    endtask

    // Issues one port word; with_irq/with_link drive those inputs with the upper half.
    task automatic send_cmd(input logic [31:0] w, input bit with_irq, input bit with_link,
                            input logic [15:0] lv);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w[15:0];
        @(negedge clk);
        check("R1 no pulse after lower half", {27'h0, got_pulses()}, 32'h0);
        wr_data = w[31:16];
        irq_raise = with_irq; link_we = with_link; link_val = lv;
        @(negedge clk);
        wr_en = 1'b0; irq_raise = 1'b0; link_we = 1'b0;
        if (with_link) m_link = lv;
        if (with_irq) m_irq = 1'b1;
        if (w[3:0] < 4'd5) m_addr = w & ~32'hF;
        else m_ill = 1'b1;
        if (w[3:0] == 4'd2) m_cfg = w & ~32'hF;
        if (w[3:0] == 4'd0) begin
            m_cfg = 32'h00FF_FFF4; m_link = 16'h8000; m_irq = 1'b0;
        end
        check("R2/R7 pulse", {27'h0, got_pulses()}, {27'h0, exp_pulses(w)});
        check_state("R3/R4/R5/R6/R7/R9/R10");
        @(negedge clk);
        check("R2 pulse lasts one cycle", {27'h0, got_pulses()}, 32'h0);
    endtask

    task automatic side_inputs(input bit do_irq, input bit do_link, input logic [15:0] lv);
        @(negedge clk);
        irq_raise = do_irq; link_we = do_link; link_val = lv;
        @(negedge clk);
        irq_raise = 1'b0; link_we = 1'b0;
        if (do_irq) m_irq = 1'b1;
        if (do_link) m_link = lv;
        check_state("R9 side inputs");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_hw_reset();
        repeat (3) @(negedge clk);
        check("R8 reset pulses", {27'h0, got_pulses()}, 32'h0);
        check_state("R8 reset state");
        rst_n = 1'b1;

        // Directed: each legal code
        send_cmd(32'hABCD_1232, 1'b0, 1'b0, 16'h0);   // alternate pointer
        send_cmd(32'h0000_2001, 1'b0, 1'b0, 16'h0);   // self-test
        send_cmd(32'h5555_AAA3, 1'b0, 1'b0, 16'h0);   // dump
        send_cmd(32'hFFFF_FFF4, 1'b0, 1'b0, 16'h0);   // attention
        side_inputs(1'b1, 1'b1, 16'h0000);             // irq raise, link down
        send_cmd(32'h0101_0100, 1'b0, 1'b0, 16'h0);   // software reset
        // Illegal codes, address must not move
        send_cmd(32'h7777_7775, 1'b0, 1'b0, 16'h0);
        send_cmd(32'h8888_888F, 1'b0, 1'b0, 16'h0);
        // Reset wins over same-cycle irq and link writes
        send_cmd(32'h0000_0000, 1'b1, 1'b1, 16'h1234);
        // Hardware reset between the two halves
        @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h0002;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        model_hw_reset();
        check_state("R8 mid-pair reset");
        rst_n = 1'b1;
        send_cmd(32'h1234_5672, 1'b0, 1'b0, 16'h0);

        // Random mix
        for (int i = 0; i < 250; i++) begin
            int unsigned sel = $urandom_range(0, 9);
            logic [31:0] w = $urandom;
            if (sel < 7) begin
                if ($urandom_range(0, 3) != 0) w[3:0] = 4'($urandom_range(0, 4));
                send_cmd(w, ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0),
                         16'($urandom));
            end else begin
                side_inputs(($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1),
                            16'($urandom));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule